// File: doc/BRIEF.md
# Mailbox Command Framer

This block turns a host command into a stream of bytes for a byte-wide mailbox. The mailbox raises a full flag when it cannot take a byte; the framer holds off while that flag is set and writes one byte in every cycle in which it is clear. Each message starts with a four-byte header (opcode, module identifier, payload length high byte, payload length low byte) and is followed by exactly that many payload bytes.

Three kinds of command are supported. A generic command sends a payload taken from a small byte buffer that the host fills beforehand. A register-write command sends a 16-bit address and a 32-bit value. A field-write command sends an address, a start bit position, a bit count and a 32-bit value. For the last two the host supplies only the fields; the framer lays them out most significant byte first. If the full flag stays set too long while a byte is pending, the message is abandoned and completion is reported with an error bit.

The host loads the buffer if needed, presents the fields and pulses `start` while `busy` is low. `busy` stays high until the single-cycle `done` pulse, which carries `done_err`.

Top module: `mbox_framer`

## Requirements
- R1: After reset `busy`, `done`, `done_err` and `mb_wr` are low.
- R2: Every message begins with four header bytes in this order: `opcode`, `module_id`, payload length bits 15:8, payload length bits 7:0.
- R3: Command kind 0 (generic) sends as payload buffer entries 0, 1, 2 ... in index order; the payload length is `gen_len`, limited to BUF_DEPTH (16 by default) when larger.
- R4: Command kind 1 (register write) has payload length 6: address bits 15:8, address bits 7:0, then value bits 31:24, 23:16, 15:8, 7:0.
- R5: Command kind 2 (field write) has payload length 8: address bits 15:8, address bits 7:0, `fld_start`, `fld_nbits`, then value bits 31:24, 23:16, 15:8, 7:0.
- R6: A generic command with length 0 writes only the four header bytes and then completes without error.
- R7: `mb_wr` is never high in a cycle in which `mb_full` is high, and while a message is in progress a byte is written in every cycle in which `mb_full` is low.
- R8: If `mb_full` is high for TIMEOUT consecutive cycles while a byte is pending, the message is abandoned: no further byte of it is written and `done` pulses with `done_err` high in the following cycle.
- R9: The full-flag wait count restarts for every byte, so a wait of TIMEOUT-1 cycles before each byte of a message ends without error.
- R10: `busy` rises in the cycle after an accepted `start` and falls in the cycle in which `done` pulses; `done` lasts one cycle and `done_err` is low after a complete message.
- R11: A `start` while `busy` is high is ignored, and the command fields are captured when `start` is accepted, so changing them during a message does not alter it.
- R12: Command kind 3 behaves exactly like kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_wr_en | input | 1 | Write strobe for the generic payload buffer |
| buf_wr_idx | input | $clog2(BUF_DEPTH) | Buffer entry to write |
| buf_wr_data | input | 8 | Byte to store in the buffer |
| start | input | 1 | Begin a message (taken only while idle) |
| cmd_kind | input | 2 | 0 generic, 1 register write, 2 field write, 3 generic |
| opcode | input | 8 | First header byte |
| module_id | input | 8 | Second header byte |
| gen_len | input | $clog2(BUF_DEPTH+1) | Generic payload length |
| reg_addr | input | 16 | Register or field address |
| reg_val | input | 32 | Register or field value |
| fld_start | input | 8 | Field start bit position |
| fld_nbits | input | 8 | Field width in bits |
| mb_full | input | 1 | Mailbox cannot accept a byte |
| mb_wr | output | 1 | Byte write strobe to the mailbox |
| mb_data | output | 8 | Byte written to the mailbox |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a timeout abort (valid with done) |

## Verification
Generic messages are swept over every length from 0 to 16 and past the buffer depth, so the header length bytes, the buffer order and the clamp are all separated from each other; register and field writes use values whose bytes all differ, which exposes any swapped or misplaced byte. Each kind runs against a free mailbox, an alternating full flag and a one-in-three full flag, and the count of busy cycles against bytes plus stalls shows that no free cycle is wasted. A full flag held for TIMEOUT-1 cycles before each byte tells a per-byte wait counter from a per-message one, while a flag stuck after a chosen byte count checks the abort point, the stall length and that nothing follows. A second start with altered fields in mid-message shows the capture at start.

// File: rtl/mbf_pkg.sv
package mbf_pkg;

  localparam int HDR_BYTES = 4;
  localparam int REG_PAY   = 6;
  localparam int FLD_PAY   = 8;

  typedef enum logic [1:0] {
    CMD_GENERIC     = 2'd0,
    CMD_REGWR       = 2'd1,
    CMD_FLDWR       = 2'd2,
    CMD_GENERIC_ALT = 2'd3
  } cmd_kind_e;

  // Payload length in bytes for a command kind.
  function automatic logic [15:0] payload_len(input logic [1:0] kind,
                                              input int gen_len,
                                              input int buf_depth);
    int n;
    case (kind)
      CMD_REGWR: n = REG_PAY;
      CMD_FLDWR: n = FLD_PAY;
      default:   n = (gen_len > buf_depth) ? buf_depth : gen_len;
    endcase
    return 16'(n);
  endfunction

  // Byte at position idx of a message (header first, then payload).
  function automatic logic [7:0] frame_byte(input logic [1:0]  kind,
                                            input logic [7:0]  op,
                                            input logic [7:0]  mid,
                                            input logic [15:0] len,
                                            input logic [15:0] addr,
                                            input logic [31:0] val,
                                            input logic [7:0]  fstart,
                                            input logic [7:0]  fnbits,
                                            input logic [7:0]  bufb,
                                            input int          idx);
    int p;
    logic [7:0] b;
    p = idx - HDR_BYTES;
    b = bufb;
    if (idx == 0)      b = op;
    else if (idx == 1) b = mid;
    else if (idx == 2) b = len[15:8];
    else if (idx == 3) b = len[7:0];
    else begin
      case (kind)
        CMD_REGWR: begin
          if (p == 0)      b = addr[15:8];
          else if (p == 1) b = addr[7:0];
          else             b = 8'(val >> (8 * (5 - p)));
        end
        CMD_FLDWR: begin
          if (p == 0)      b = addr[15:8];
          else if (p == 1) b = addr[7:0];
          else if (p == 2) b = fstart;
          else if (p == 3) b = fnbits;
          else             b = 8'(val >> (8 * (7 - p)));
        end
        default: b = bufb;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/mbf_payload_buf.sv
module mbf_payload_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/mbf_seq.sv
module mbf_seq #(
  parameter int TIMEOUT = 64,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] total_in,
  input  logic             mb_full,
  output logic             start_acc,
  output logic [IDX_W-1:0] send_idx,
  output logic             mb_wr,
  output logic             busy,
  output logic             done,
  output logic             done_err
);

  localparam int WAIT_W = $clog2(TIMEOUT) + 1;

  logic              sending;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  total_q;
  logic [WAIT_W-1:0] wait_cnt;

  // Named internal events.
  logic byte_accept;
  logic last_byte;
  logic wait_expired;

  assign start_acc    = start && !sending;
  assign byte_accept  = sending && !mb_full;
  assign last_byte    = (idx_q == total_q - IDX_W'(1));
  assign wait_expired = sending && mb_full && (wait_cnt == WAIT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending  <= 1'b0;
      idx_q    <= '0;
      total_q  <= '0;
      wait_cnt <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      if (start_acc) begin
        sending  <= 1'b1;
        idx_q    <= '0;
        total_q  <= total_in;
        wait_cnt <= '0;
      end else if (byte_accept) begin
        wait_cnt <= '0;
        if (last_byte) begin
          sending <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (wait_expired) begin
        sending  <= 1'b0;
        done     <= 1'b1;
        done_err <= 1'b1;
      end else if (sending) begin
        wait_cnt <= wait_cnt + WAIT_W'(1);
      end
    end
  end

  assign send_idx = idx_q;
  assign mb_wr    = byte_accept;
  assign busy     = sending;

  // R10: completion is a single-cycle pulse.
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy only drops together with done.
  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10: an idle start makes the block busy in the next cycle.
  a_r10_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8: an error completion is always preceded by a pending byte under full.
  a_r8_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> ($past(mb_full) && $past(busy)));

  // R11: the message length captured at start does not move mid-message.
  a_r11_total_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(total_q));

  // R7: the byte position never passes the end of the message.
  a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q < total_q));

endmodule

// File: rtl/mbox_framer.sv
module mbox_framer #(
  parameter int BUF_DEPTH = 16,
  parameter int TIMEOUT   = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           buf_wr_en,
  input  logic [$clog2(BUF_DEPTH)-1:0]   buf_wr_idx,
  input  logic [7:0]                     buf_wr_data,
  input  logic                           start,
  input  logic [1:0]                     cmd_kind,
  input  logic [7:0]                     opcode,
  input  logic [7:0]                     module_id,
  input  logic [$clog2(BUF_DEPTH+1)-1:0] gen_len,
  input  logic [15:0]                    reg_addr,
  input  logic [31:0]                    reg_val,
  input  logic [7:0]                     fld_start,
  input  logic [7:0]                     fld_nbits,
  input  logic                           mb_full,
  output logic                           mb_wr,
  output logic [7:0]                     mb_data,
  output logic                           busy,
  output logic                           done,
  output logic                           done_err
);
  import mbf_pkg::*;

  localparam int BUF_AW = $clog2(BUF_DEPTH);
  localparam int MAXPAY = (BUF_DEPTH > FLD_PAY) ? BUF_DEPTH : FLD_PAY;
  localparam int IDX_W  = $clog2(HDR_BYTES + MAXPAY + 1);

  // Captured command fields.
  logic [1:0]  kind_q;
  logic [7:0]  op_q, mid_q, fs_q, fn_q;
  logic [15:0] len_q, addr_q;
  logic [31:0] val_q;

  logic [15:0]      len_now;
  logic [IDX_W-1:0] total_now;
  logic             start_acc;
  logic [IDX_W-1:0] send_idx;
  logic [IDX_W-1:0] pay_idx;
  logic [7:0]       buf_byte;

  assign len_now   = payload_len(cmd_kind, int'(gen_len), BUF_DEPTH);
  assign total_now = IDX_W'(HDR_BYTES) + IDX_W'(len_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= '0;
      op_q   <= '0;
      mid_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
      val_q  <= '0;
      fs_q   <= '0;
      fn_q   <= '0;
    end else if (start_acc) begin
      kind_q <= cmd_kind;
      op_q   <= opcode;
      mid_q  <= module_id;
      len_q  <= len_now;
      addr_q <= reg_addr;
      val_q  <= reg_val;
      fs_q   <= fld_start;
      fn_q   <= fld_nbits;
    end
  end

  mbf_seq #(
    .TIMEOUT (TIMEOUT),
    .IDX_W   (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .total_in  (total_now),
    .mb_full   (mb_full),
    .start_acc (start_acc),
    .send_idx  (send_idx),
    .mb_wr     (mb_wr),
    .busy      (busy),
    .done      (done),
    .done_err  (done_err)
  );

  assign pay_idx = send_idx - IDX_W'(HDR_BYTES);

  mbf_payload_buf #(
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr_en),
    .wr_idx  (buf_wr_idx),
    .wr_data (buf_wr_data),
    .rd_idx  (pay_idx[BUF_AW-1:0]),
    .rd_data (buf_byte)
  );

  assign mb_data = frame_byte(kind_q, op_q, mid_q, len_q, addr_q, val_q,
                              fs_q, fn_q, buf_byte, int'(send_idx));

  // R2: the first byte of a message is the captured opcode.
  a_r2_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && send_idx == '0) |-> (mb_data == op_q));

endmodule

// File: tb/sim_mbox_framer.sv
module sim_mbox_framer;

  localparam int TO    = 8;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        buf_wr_en;
  logic [3:0]  buf_wr_idx;
  logic [7:0]  buf_wr_data;
  logic        start;
  logic [1:0]  cmd_kind;
  logic [7:0]  opcode, module_id, fld_start, fld_nbits;
  logic [4:0]  gen_len;
  logic [15:0] reg_addr;
  logic [31:0] reg_val;
  logic        mb_full;
  logic        mb_wr, busy, done, done_err;
  logic [7:0]  mb_data;

  always #5 clk = ~clk;

  mbox_framer #(.BUF_DEPTH(DEPTH), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
    .start(start), .cmd_kind(cmd_kind), .opcode(opcode), .module_id(module_id),
    .gen_len(gen_len), .reg_addr(reg_addr), .reg_val(reg_val),
    .fld_start(fld_start), .fld_nbits(fld_nbits),
    .mb_full(mb_full), .mb_wr(mb_wr), .mb_data(mb_data),
    .busy(busy), .done(done), .done_err(done_err)
  );

  int tests = 0;
  int fails = 0;

  // Mailbox full-flag model.
  int fmode    = 0;
  int stuck_at = 0;
  int cyc      = 0;

  // Capture state, filled just before each rising edge.
  logic [7:0] cap [32];
  int ncap, busy_cnt, stall_cnt, done_seen, wr_full_cnt;
  logic last_err;
  logic [7:0] bufimg [DEPTH];

  always @(negedge clk) begin
    cyc++;
    case (fmode)
      1: mb_full = cyc[0];
      2: mb_full = (cyc % 3) == 0;
      3: mb_full = (cyc % TO) != (TO - 1);
      4: mb_full = (ncap >= stuck_at);
      default: mb_full = 1'b0;
    endcase
  end

  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (mb_wr) begin
        if (ncap < 32) cap[ncap] = mb_data;
        ncap++;
        if (mb_full) wr_full_cnt++;
      end
      if (busy) busy_cnt++;
      if (busy && mb_full) stall_cnt++;
      if (done) begin
        done_seen++;
        last_err = done_err;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic load_buf(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      bufimg[i]   = 8'((i * 29 + seed) & 255);
      buf_wr_en   = 1'b1;
      buf_wr_idx  = 4'(i);
      buf_wr_data = bufimg[i];
    end
    @(negedge clk);
    buf_wr_en = 1'b0;
  endtask

  // Run the command held in the input signals and check the frame.
  task automatic run(input string req, input int exp_err, input int stuck_bytes,
                     input bit disturb);
    logic [7:0]  expb [32];
    logic [47:0] rw;
    logic [63:0] fw;
    int plen, en, mis, waited;
    logic [1:0]  k;
    k = cmd_kind;
    plen = (k == 2'd1) ? 6 : (k == 2'd2) ? 8 : ((gen_len > DEPTH) ? DEPTH : int'(gen_len));
    en = 4 + plen;
    expb[0] = opcode;
    expb[1] = module_id;
    expb[2] = 8'(plen >> 8);
    expb[3] = 8'(plen & 255);
    rw = {reg_addr, reg_val};
    fw = {reg_addr, fld_start, fld_nbits, reg_val};
    for (int p = 0; p < plen; p++) begin
      if (k == 2'd1)      expb[4 + p] = rw[47 - 8 * p -: 8];
      else if (k == 2'd2) expb[4 + p] = fw[63 - 8 * p -: 8];
      else                expb[4 + p] = bufimg[p];
    end
    @(negedge clk);
    ncap = 0; busy_cnt = 0; stall_cnt = 0; done_seen = 0; wr_full_cnt = 0;
    last_err = 1'b0;
    stuck_at = stuck_bytes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (done_seen == 0 && waited < 400) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 2) begin
        start    = 1'b1;
        cmd_kind = 2'd2;
        reg_addr = ~reg_addr;
        reg_val  = ~reg_val;
      end else if (disturb && waited == 3) begin
        start = 1'b0;
      end
      #5;
    end
    chk(done_seen == 1, "R10", {req, " done pulse count"}, done_seen, 1);
    chk(last_err == 1'(exp_err), exp_err ? "R8" : "R10", {req, " done_err"}, last_err, exp_err);
    chk(wr_full_cnt == 0, "R7", {req, " writes while full"}, wr_full_cnt, 0);
    if (exp_err != 0) begin
      chk(ncap == stuck_bytes, "R8", {req, " bytes before abort"}, ncap, stuck_bytes);
      chk(stall_cnt == TO, "R8", {req, " stall cycles before abort"}, stall_cnt, TO);
      en = stuck_bytes;
    end else begin
      chk(ncap == en, req, "byte count", ncap, en);
      chk(busy_cnt == en + stall_cnt, "R10", {req, " busy cycles"}, busy_cnt, en + stall_cnt);
    end
    mis = -1;
    for (int i = 0; i < en && i < 32; i++)
      if (mis < 0 && cap[i] !== expb[i]) mis = i;
    if (mis >= 0)
      chk(1'b0, (mis < 4) ? "R2" : req, $sformatf("byte %0d", mis), cap[mis], expb[mis]);
    else
      chk(1'b1, req, "bytes", 0, 0);
    // Nothing more after completion.
    repeat (3) @(negedge clk);
    #5;
    chk(ncap == en && busy == 1'b0, disturb ? "R11" : "R8",
        {req, " quiet after done"}, ncap, en);
  endtask

  task automatic set_cmd(input logic [1:0] k, input int glen, input int seed);
    cmd_kind  = k;
    opcode    = 8'(8'hA0 + seed);
    module_id = 8'(8'h11 * (seed % 7 + 1));
    gen_len   = 5'(glen);
    reg_addr  = 16'(16'h3C5A ^ (seed * 16'h0101));
    reg_val   = 32'h8142_C3E7 ^ (32'(seed) * 32'h0102_0408);
    fld_start = 8'(seed % 32);
    fld_nbits = 8'(seed % 5 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; buf_wr_en = 1'b0; buf_wr_idx = '0; buf_wr_data = '0;
    set_cmd(2'd0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1: reset state
    chk(busy == 0 && done == 0 && mb_wr == 0 && done_err == 0, "R1", "idle after reset",
        {busy, done, mb_wr, done_err}, 0);

    load_buf(7);
    // R3, R6: generic sweep with several full-flag patterns.
    for (int L = 0; L <= 17; L++) begin
      fmode = L % 3;
      set_cmd(2'd0, L, L);
      run(L == 0 ? "R6" : "R3", 0, 0, 1'b0);
    end
    fmode = 1; set_cmd(2'd0, 20, 3); run("R3", 0, 0, 1'b0);   // clamp
    fmode = 0; set_cmd(2'd0, 31, 4); run("R3", 0, 0, 1'b0);   // clamp
    load_buf(200);
    fmode = 2; set_cmd(2'd0, 16, 9); run("R3", 0, 0, 1'b0);

    // R4: register writes
    for (int s = 0; s < 4; s++) begin
      fmode = s % 3;
      set_cmd(2'd1, 0, s + 1);
      run("R4", 0, 0, 1'b0);
    end
    // R5: field writes
    for (int s = 0; s < 4; s++) begin
      fmode = (s + 1) % 3;
      set_cmd(2'd2, 0, s + 5);
      run("R5", 0, 0, 1'b0);
    end
    // R12: kind 3 as generic
    fmode = 1; set_cmd(2'd3, 5, 12); run("R12", 0, 0, 1'b0);
    fmode = 0; set_cmd(2'd3, 16, 13); run("R12", 0, 0, 1'b0);

    // R9: TIMEOUT-1 wait before every byte
    fmode = 3; set_cmd(2'd1, 0, 14); run("R9", 0, 0, 1'b0);
    fmode = 3; set_cmd(2'd2, 0, 15); run("R9", 0, 0, 1'b0);
    fmode = 3; set_cmd(2'd0, 16, 16); run("R9", 0, 0, 1'b0);

    // R8: full flag stuck at several points
    fmode = 4; set_cmd(2'd1, 0, 17); run("R8", 1, 0, 1'b0);
    fmode = 4; set_cmd(2'd1, 0, 18); run("R8", 1, 3, 1'b0);
    fmode = 4; set_cmd(2'd1, 0, 19); run("R8", 1, 9, 1'b0);
    fmode = 4; set_cmd(2'd0, 16, 20); run("R8", 1, 19, 1'b0);

    // R11: second start and changed fields while busy
    fmode = 1; set_cmd(2'd1, 0, 21); run("R11", 0, 0, 1'b1);
    fmode = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule